// File: doc/BRIEF.md
# Load/Store Address Generation Unit

This block works out where a load or store goes in memory and, for the
indexing modes that change the base register, what new value the base takes.
It takes a base register value and forms an offset from one of three sources:
an immediate constant, an index register, or an index register moved left by a
shift count. It then adds the offset to the base or subtracts it from the base.

An addressing-mode selector decides how the result is used. In plain offset
mode the sum is the access address and the base stays as it is. In pre-indexed
mode the sum is both the access address and the new base. In post-indexed mode
the access goes to the untouched base and the sum becomes the new base. The
results are captured in output registers on a rising clock edge when a request
strobe is high, so the surrounding pipeline sees them one cycle later. The
block does not read the register file, the memory interface or the instruction
decoder.

Top module: `ls_agu_top`

## Requirements
- R1: Offset mode (`idx_mode` = 0): `ea_out` is the base combined with the offset, `wb_en` is 0, and `wb_data` still carries that same combined value.
- R2: Pre-indexed mode (`idx_mode` = 1): `ea_out` is the base combined with the offset, `wb_en` is 1, and `wb_data` equals `ea_out`.
- R3: Post-indexed mode (`idx_mode` = 2): `ea_out` is the unmodified base, `wb_en` is 1, and `wb_data` is the base combined with the offset.
- R4: Offset source (`ofs_src`): 0 selects `imm_val`, 1 selects `idx_val`, 2 selects `idx_val` shifted left by `shamt`, and code 3 behaves like code 0.
- R5: The shift count `shamt` is 5 bits (0 to 31); zeros enter from the bottom and bits moved past bit 31 are lost.
- R6: `sub_ofs` = 0 adds the offset to the base and `sub_ofs` = 1 subtracts it; both wrap modulo 2^32.
- R7: Mode code 3 behaves like offset mode: `ea_out` is the combined value and `wb_en` is 0.
- R8: A request with `req_valid` high at a rising edge shows its results on `ea_out`, `wb_en` and `wb_data` after that edge, with `res_valid` high for exactly that one cycle.
- R9: At an edge where `req_valid` is low, `ea_out`, `wb_en` and `wb_data` keep their values and `res_valid` goes to 0. Changing other inputs at that edge has no effect.
- R10: While `rst_n` is low at a rising edge, all outputs become 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Request strobe; the inputs are captured when it is high |
| base_val | input | 32 | Base register value |
| ofs_src | input | 2 | Offset source: 0 immediate, 1 index, 2 shifted index |
| imm_val | input | 32 | Immediate offset constant |
| idx_val | input | 32 | Index register value |
| shamt | input | 5 | Left shift count for the shifted index source |
| sub_ofs | input | 1 | 1 subtracts the offset, 0 adds it |
| idx_mode | input | 2 | Mode: 0 offset, 1 pre-indexed, 2 post-indexed |
| ea_out | output | 32 | Registered effective address |
| wb_en | output | 1 | Registered base write-back enable |
| wb_data | output | 32 | Registered base write-back value |
| res_valid | output | 1 | High for the cycle after a captured request |

## Verification
Each mode is given the same base and offset, so a swap between the access
address and the write-back value in pre- and post-indexed modes shows up as a
mismatch. The immediate and index values are set to different numbers, which
shows whether the wrong offset source was picked. Shift counts of 0, 1, 4 and
31 with high index bits set check that bits leave at the top rather than
rotate. Subtractions that go below zero and additions that pass 2^32 check
the wrap, and a long run of pseudo-random requests mixes everything. Idle
cycles with changing inputs and a reset in the middle of the run check that the
outputs hold and then clear.

// File: rtl/agu_pkg.sv
// Package: shared encodings for the load/store address generator.
// Assumes 2-bit selector fields; unused codes are folded by the users.
package agu_pkg;

    // Where the offset comes from.
    typedef enum logic [1:0] {
        SRC_IMM   = 2'd0,
        SRC_IDX   = 2'd1,
        SRC_SHIDX = 2'd2,
        SRC_RSVD  = 2'd3
    } ofs_src_e;

    // How the computed sum is used.
    typedef enum logic [1:0] {
        MODE_OFFSET = 2'd0,
        MODE_PRE    = 2'd1,
        MODE_POST   = 2'd2,
        MODE_RSVD   = 2'd3
    } idx_mode_e;

endpackage

// File: rtl/agu_offset_sel.sv
// Module: agu_offset_sel
// Picks the offset operand: immediate, index register, or index register
// shifted left by a count. Purely combinational. Assumes the shift count fits
// in SHAMT_W bits; bits moved past the top are dropped and the reserved source
// code falls back to the immediate.
module agu_offset_sel
    import agu_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int SHAMT_W = $clog2(DATA_W)
) (
    input  logic [1:0]         src_sel,
    input  logic [DATA_W-1:0]  imm_in,
    input  logic [DATA_W-1:0]  idx_in,
    input  logic [SHAMT_W-1:0] shift_cnt,
    output logic [DATA_W-1:0]  ofs_out
);

    logic [DATA_W-1:0] shifted_idx;

    // Logical left shift of the index register; zeros enter at the bottom.
    always_comb begin
        shifted_idx = idx_in << shift_cnt;
    end

    // Offset source multiplexer.
    always_comb begin
        unique case (ofs_src_e'(src_sel))
            SRC_IDX:   ofs_out = idx_in;
            SRC_SHIDX: ofs_out = shifted_idx;
            default:   ofs_out = imm_in;
        endcase
    end

endmodule

// File: rtl/agu_addsub.sv
// Module: agu_addsub
// Adds or subtracts the offset from the base, wrapping modulo 2^DATA_W.
// SHARED_ADDER chooses the structure: 1 builds one adder fed with the
// inverted operand and a carry-in, 0 builds separate add and subtract paths
// followed by a multiplexer. Both give the same result.
module agu_addsub #(
    parameter int DATA_W       = 32,
    parameter bit SHARED_ADDER = 1'b1
) (
    input  logic [DATA_W-1:0] base_in,
    input  logic [DATA_W-1:0] ofs_in,
    input  logic              do_sub,
    output logic [DATA_W-1:0] sum_out
);

    generate
        if (SHARED_ADDER) begin : g_shared
            logic [DATA_W-1:0] ofs_eff;
            logic [DATA_W-1:0] cin_vec;

            // Invert the operand for subtraction and add one through the carry-in.
            always_comb begin
                ofs_eff = ofs_in ^ {DATA_W{do_sub}};
                cin_vec = {{(DATA_W-1){1'b0}}, do_sub};
                sum_out = base_in + ofs_eff + cin_vec;
            end
        end else begin : g_split
            logic [DATA_W-1:0] add_res;
            logic [DATA_W-1:0] sub_res;

            // Two arithmetic paths run in parallel; do_sub picks one.
            always_comb begin
                add_res = base_in + ofs_in;
                sub_res = base_in - ofs_in;
                sum_out = do_sub ? sub_res : add_res;
            end
        end
    endgenerate

endmodule

// File: rtl/agu_mode_route.sv
// Module: agu_mode_route
// Routes the base and the sum to the access address and the write-back value
// according to the indexing mode. Combinational. The reserved mode code acts
// as plain offset mode. The write-back value is always the sum.
module agu_mode_route
    import agu_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [1:0]        mode_sel,
    input  logic [DATA_W-1:0] base_in,
    input  logic [DATA_W-1:0] sum_in,
    output logic [DATA_W-1:0] ea_nxt,
    output logic              wb_en_nxt,
    output logic [DATA_W-1:0] wb_data_nxt
);

    // Select the access address and the write-back enable for each mode.
    always_comb begin
        wb_data_nxt = sum_in;
        unique case (idx_mode_e'(mode_sel))
            MODE_PRE: begin
                ea_nxt    = sum_in;
                wb_en_nxt = 1'b1;
            end
            MODE_POST: begin
                ea_nxt    = base_in;
                wb_en_nxt = 1'b1;
            end
            default: begin
                ea_nxt    = sum_in;
                wb_en_nxt = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/agu_out_reg.sv
// Module: agu_out_reg
// Output register stage. It loads the routed results when the request strobe
// is high and holds them otherwise. res_q is high for one cycle after each
// load. A synchronous active-low reset clears everything.
module agu_out_reg #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] ea_d,
    input  logic              wb_en_d,
    input  logic [DATA_W-1:0] wb_data_d,
    output logic [DATA_W-1:0] ea_q,
    output logic              wb_en_q,
    output logic [DATA_W-1:0] wb_data_q,
    output logic              res_q
);

    // Result registers: clear on reset, load on request, otherwise hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ea_q      <= '0;
            wb_en_q   <= 1'b0;
            wb_data_q <= '0;
        end else if (load) begin
            ea_q      <= ea_d;
            wb_en_q   <= wb_en_d;
            wb_data_q <= wb_data_d;
        end
    end

    // One-cycle flag marking a fresh result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_q <= 1'b0;
        end else begin
            res_q <= load;
        end
    end

endmodule

// File: rtl/ls_agu_top.sv
// Module: ls_agu_top
// Load/store address generator. It forms an offset, adds it to or subtracts
// it from the base, routes the base and the sum by indexing mode, and
// registers the effective address, the write-back enable and the write-back
// value. Assumes the request inputs are stable around the clock edge where
// req_valid is sampled.
module ls_agu_top #(
    parameter int ADDR_W       = 32,
    parameter bit SHARED_ADDER = 1'b1,
    localparam int SHAMT_W     = $clog2(ADDR_W)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic [ADDR_W-1:0]  base_val,
    input  logic [1:0]         ofs_src,
    input  logic [ADDR_W-1:0]  imm_val,
    input  logic [ADDR_W-1:0]  idx_val,
    input  logic [SHAMT_W-1:0] shamt,
    input  logic               sub_ofs,
    input  logic [1:0]         idx_mode,
    output logic [ADDR_W-1:0]  ea_out,
    output logic               wb_en,
    output logic [ADDR_W-1:0]  wb_data,
    output logic               res_valid
);

    logic [ADDR_W-1:0] ofs_w;
    logic [ADDR_W-1:0] sum_w;
    logic [ADDR_W-1:0] ea_w;
    logic              wb_en_w;
    logic [ADDR_W-1:0] wb_data_w;

    agu_offset_sel #(
        .DATA_W  (ADDR_W),
        .SHAMT_W (SHAMT_W)
    ) ofs_sel_i (
        .src_sel   (ofs_src),
        .imm_in    (imm_val),
        .idx_in    (idx_val),
        .shift_cnt (shamt),
        .ofs_out   (ofs_w)
    );

    agu_addsub #(
        .DATA_W       (ADDR_W),
        .SHARED_ADDER (SHARED_ADDER)
    ) addsub_i (
        .base_in (base_val),
        .ofs_in  (ofs_w),
        .do_sub  (sub_ofs),
        .sum_out (sum_w)
    );

    agu_mode_route #(
        .DATA_W (ADDR_W)
    ) route_i (
        .mode_sel    (idx_mode),
        .base_in     (base_val),
        .sum_in      (sum_w),
        .ea_nxt      (ea_w),
        .wb_en_nxt   (wb_en_w),
        .wb_data_nxt (wb_data_w)
    );

    agu_out_reg #(
        .DATA_W (ADDR_W)
    ) oreg_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (req_valid),
        .ea_d      (ea_w),
        .wb_en_d   (wb_en_w),
        .wb_data_d (wb_data_w),
        .ea_q      (ea_out),
        .wb_en_q   (wb_en),
        .wb_data_q (wb_data),
        .res_q     (res_valid)
    );

endmodule

// File: rtl/ls_agu_chk.sv
// Module: ls_agu_chk
// Checker bound to ls_agu_top. It relates the request inputs to the
// registered outputs one cycle later.
module ls_agu_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic [ADDR_W-1:0] base_val,
    input logic [ADDR_W-1:0] imm_val,
    input logic [1:0]        ofs_src,
    input logic              sub_ofs,
    input logic [1:0]        idx_mode,
    input logic [ADDR_W-1:0] ea_out,
    input logic              wb_en,
    input logic [ADDR_W-1:0] wb_data,
    input logic              res_valid
);

    // R8: a captured request raises res_valid on the next cycle.
    a_r8_result_flag: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> res_valid);

    // R9: no request means the results stay the same and the flag drops.
    a_r9_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!res_valid && $stable(ea_out) && $stable(wb_en) && $stable(wb_data)));

    // R3: post-indexed access goes to the old base.
    a_r3_post_base: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && idx_mode == 2'd2) |=> (ea_out == $past(base_val) && wb_en));

    // R2: pre-indexed write-back equals the access address.
    a_r2_pre_same: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && idx_mode == 2'd1) |=> (wb_en && wb_data == ea_out));

    // R1 and R7: offset mode and the reserved mode never write back.
    a_r1_no_wb: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && (idx_mode == 2'd0 || idx_mode == 2'd3)) |=> (!wb_en && wb_data == ea_out));

    // R6: immediate add in offset mode gives base plus immediate.
    a_r6_imm_add: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && idx_mode == 2'd0 && ofs_src == 2'd0 && !sub_ofs)
        |=> (ea_out == $past(base_val + imm_val)));

    // R10: reset clears every output.
    a_r10_reset_clear: assert property (@(posedge clk)
        !rst_n |=> (ea_out == '0 && !wb_en && wb_data == '0 && !res_valid));

endmodule

bind ls_agu_top ls_agu_chk #(.ADDR_W(ADDR_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .base_val  (base_val),
    .imm_val   (imm_val),
    .ofs_src   (ofs_src),
    .sub_ofs   (sub_ofs),
    .idx_mode  (idx_mode),
    .ea_out    (ea_out),
    .wb_en     (wb_en),
    .wb_data   (wb_data),
    .res_valid (res_valid)
);

// File: tb/ls_agu_tb_top.sv
// Scoreboard bench for ls_agu_top. The driver computes the expected results
// from the requirements and queues them; the monitor compares each result as
// it appears.
module ls_agu_tb_top;

    typedef struct {
        logic [31:0] ea;
        logic        wbe;
        logic [31:0] wbd;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] base_val = '0;
    logic [1:0]  ofs_src = '0;
    logic [31:0] imm_val = '0;
    logic [31:0] idx_val = '0;
    logic [4:0]  shamt = '0;
    logic        sub_ofs = 1'b0;
    logic [1:0]  idx_mode = '0;
    logic [31:0] ea_out;
    logic        wb_en;
    logic [31:0] wb_data;
    logic        res_valid;

    int   n_checks = 0;
    int   n_fail = 0;
    bit   finished = 1'b0;
    exp_t sb_q[$];
    exp_t last_exp;

    always #2.5 clk = ~clk;

    ls_agu_top dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .base_val  (base_val),
        .ofs_src   (ofs_src),
        .imm_val   (imm_val),
        .idx_val   (idx_val),
        .shamt     (shamt),
        .sub_ofs   (sub_ofs),
        .idx_mode  (idx_mode),
        .ea_out    (ea_out),
        .wb_en     (wb_en),
        .wb_data   (wb_data),
        .res_valid (res_valid)
    );

    // Counts one check and prints a line when it fails.
    task automatic check(input bit ok, input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // Driver: applies one request and queues the expected result.
    task automatic issue(input logic [31:0] b, input logic [1:0] src,
                         input logic [31:0] imm, input logic [31:0] idx,
                         input logic [4:0] sh, input logic sub,
                         input logic [1:0] mode, input string tag);
        logic [31:0] ofs;
        logic [31:0] sum;
        exp_t e;
        @(negedge clk);
        base_val = b; ofs_src = src; imm_val = imm; idx_val = idx;
        shamt = sh; sub_ofs = sub; idx_mode = mode; req_valid = 1'b1;
        ofs = (src == 2'd1) ? idx : (src == 2'd2) ? (idx << sh) : imm;
        sum = sub ? (b - ofs) : (b + ofs);
        e.tag = tag;
        e.wbd = sum;
        if (mode == 2'd1) begin
            e.ea = sum; e.wbe = 1'b1;
        end else if (mode == 2'd2) begin
            e.ea = b; e.wbe = 1'b1;
        end else begin
            e.ea = sum; e.wbe = 1'b0;
        end
        sb_q.push_back(e);
        last_exp = e;
    endtask

    // Driver: idle cycle with random noise on the data inputs.
    task automatic idle();
        @(negedge clk);
        req_valid = 1'b0;
        base_val = $urandom; imm_val = $urandom; idx_val = $urandom;
        ofs_src = 2'($urandom); idx_mode = 2'($urandom);
        shamt = 5'($urandom); sub_ofs = 1'($urandom);
    endtask

    // Monitor: pops and compares each result in the cycle it appears.
    always @(negedge clk) begin
        if (rst_n && res_valid) begin
            if (sb_q.size() == 0) begin
                check(1'b0, "R8", "unexpected res_valid", 32'd1, 32'd0);
            end else begin
                exp_t e;
                e = sb_q.pop_front();
                check(ea_out == e.ea, e.tag, "ea_out", ea_out, e.ea);
                check(wb_en == e.wbe, e.tag, "wb_en", {31'd0, wb_en}, {31'd0, e.wbe});
                check(wb_data == e.wbd, e.tag, "wb_data", wb_data, e.wbd);
            end
        end
    end

    // Watchdog: ends a hung run as a failure.
    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", sb_q.size(), 0);
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        // R10: reset state.
        repeat (3) @(negedge clk);
        check(ea_out == 32'd0 && wb_data == 32'd0, "R10", "reset data", ea_out | wb_data, 32'd0);
        check(!wb_en && !res_valid, "R10", "reset flags", {30'd0, wb_en, res_valid}, 32'd0);
        rst_n = 1'b1;

        // R1, R2, R3: same operands in every mode.
        issue(32'h0000_1000, 2'd0, 32'h24, 32'h500, 5'd0, 1'b0, 2'd0, "R1");
        issue(32'h0000_1000, 2'd0, 32'h24, 32'h500, 5'd0, 1'b0, 2'd1, "R2");
        issue(32'h0000_1000, 2'd0, 32'h24, 32'h500, 5'd0, 1'b0, 2'd2, "R3");
        issue(32'h0000_1000, 2'd0, 32'h24, 32'h500, 5'd0, 1'b1, 2'd2, "R3");
        // R7: reserved mode behaves like offset mode.
        issue(32'h0000_2000, 2'd1, 32'h24, 32'h500, 5'd0, 1'b0, 2'd3, "R7");
        // R4: each source, distinct immediate and index values.
        issue(32'h0000_1000, 2'd1, 32'h24, 32'h500, 5'd3, 1'b0, 2'd0, "R4");
        issue(32'h0000_1000, 2'd2, 32'h24, 32'h500, 5'd3, 1'b0, 2'd1, "R4");
        issue(32'h0000_1000, 2'd3, 32'h24, 32'h500, 5'd3, 1'b0, 2'd0, "R4");
        // R5: shift edges, bits leave at the top.
        issue(32'h0, 2'd2, 32'h0, 32'hF000_0003, 5'd0,  1'b0, 2'd0, "R5");
        issue(32'h0, 2'd2, 32'h0, 32'hF000_0003, 5'd1,  1'b0, 2'd0, "R5");
        issue(32'h0, 2'd2, 32'h0, 32'hF000_0003, 5'd4,  1'b0, 2'd0, "R5");
        issue(32'h0, 2'd2, 32'h0, 32'h0000_0003, 5'd31, 1'b0, 2'd0, "R5");
        // R6: wrap on add and subtract.
        issue(32'hFFFF_FFF0, 2'd0, 32'h20, 32'h0, 5'd0, 1'b0, 2'd1, "R6");
        issue(32'h0000_0004, 2'd0, 32'h8,  32'h0, 5'd0, 1'b1, 2'd0, "R6");
        issue(32'h0000_0004, 2'd2, 32'h0,  32'h1, 5'd31, 1'b1, 2'd2, "R6");

        // R9: idle cycles hold the last result.
        idle();
        for (int i = 0; i < 3; i++) begin
            idle();
            check(!res_valid, "R9", "res_valid idle", {31'd0, res_valid}, 32'd0);
            check(ea_out == last_exp.ea && wb_data == last_exp.wbd && wb_en == last_exp.wbe,
                  "R9", "held ea_out", ea_out, last_exp.ea);
        end

        // R8: back-to-back and gapped random requests.
        for (int i = 0; i < 300; i++) begin
            issue($urandom, 2'($urandom), $urandom, $urandom, 5'($urandom),
                  1'($urandom), 2'($urandom), "R8");
            if ((i % 7) == 0) idle();
        end
        idle();
        idle();

        // R10: reset in the middle of the run.
        issue(32'hDEAD_0000, 2'd0, 32'h10, 32'h0, 5'd0, 1'b0, 2'd1, "R2");
        idle();
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check(ea_out == 32'd0 && wb_data == 32'd0, "R10", "mid reset data", ea_out | wb_data, 32'd0);
        check(!wb_en && !res_valid, "R10", "mid reset flags", {30'd0, wb_en, res_valid}, 32'd0);
        rst_n = 1'b1;
        idle();
        check(sb_q.size() == 0, "R8", "scoreboard drained", sb_q.size(), 32'd0);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

endmodule